// File: doc/BRIEF.md
# Cache-Line Aligned Read Burst Shaper

This block sits beside the bus-master engine of a transmit DMA and decides when a read burst should end. It tracks the dword address of the running burst and the number of bytes it has moved. It raises a registered stop request when the transmit FIFO nears full. It raises a handover request when a configured byte budget is spent while another DMA channel waits. The bus engine ends the burst and acknowledges, which clears both requests.

With the alignment mode on, both kinds of termination wait for the next cache-line boundary. The following transaction, which resumes at the stop address, therefore starts on a line-aligned address. With the mode off, the block is a plain burst limiter that reacts on the next cycle. The line size is a power of two in dwords, and 8 and 16 dwords are the expected settings. Control pins are plain levels and strobes. No data passes through the block, so it has no valid/ready interface. `beat` marks a completed data phase and exerts no back-pressure.

Top module: `rd_burst_shaper`

## Requirements
- R1: After reset, `stop_req` and `handover_req` are 0 and `rd_addr` is 0.
- R2: A cycle with `txn_start` loads `rd_addr` with `start_addr`. Otherwise, each cycle with `beat` high adds one to `rd_addr`. The new value is visible after the clock edge.
- R3: With `align_en` = 0, a cycle in which a burst is open, `fifo_afull` is 1, and neither `txn_start` nor `burst_end_ack` is high is followed by `stop_req` = 1 on the next cycle.
- R4: With `align_en` = 1, a `fifo_afull` seen during an open burst is remembered. `stop_req` rises at the first edge where the address after that cycle's beat has its low `cls_log2` bits all zero.
- R5: With `align_en` = 1, if the address is already on a line boundary when `fifo_afull` is seen, `stop_req` rises on the next cycle and no further line is transferred first.
- R6: `stop_req` and `handover_req` stay high until a cycle with `burst_end_ack` or `txn_start`. After that edge both are 0, and `burst_end_ack` also closes the burst.
- R7: The byte count resets to 0 at `txn_start` and grows by 4 per beat. An `arb_limit` of 0 disables handover entirely.
- R8: With `align_en` = 0, `handover_req` rises at the edge where the byte count after that cycle's beat is at least `arb_limit` (non-zero) while `other_pend` is 1.
- R9: With `align_en` = 1, the handover condition of R8 must also fall on a line boundary, tested as in R4.
- R10: The line size is 2^`cls_log2` dwords. Both `cls_log2` = 3 (8 dwords) and 4 (16 dwords) set the boundary used by R4, R5 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| align_en | input | 1 | Defer terminations to line boundaries |
| cls_log2 | input | 3 | Log2 of cache line size in dwords |
| txn_start | input | 1 | Strobe: a new read burst begins |
| start_addr | input | 30 | Dword address of the new burst |
| beat | input | 1 | Strobe: one dword data phase completed |
| fifo_afull | input | 1 | Transmit FIFO almost full |
| arb_limit | input | 16 | Byte budget before handover, 0 = off |
| other_pend | input | 1 | Another DMA channel is waiting |
| burst_end_ack | input | 1 | Bus engine has ended the burst |
| stop_req | output | 1 | Registered request to end the burst |
| handover_req | output | 1 | Registered request to yield to another DMA |
| rd_addr | output | 30 | Current dword address of the burst |

## Verification
Every cycle, the assertions check four things. The requests must hold until acknowledged and must clear after the acknowledge. An unaligned almost-full must produce a stop on the following cycle. In aligned mode, a rising stop or handover must coincide with a line-aligned address, and a handover must follow a pending request from another channel. Only the bench scenarios can show the rest. These cover:
- waiting across a whole partial line before stopping;
- stopping at once when already aligned;
- the exact cycle at which the byte budget runs out;
- a zero budget suppressing handover;
- the difference between 8- and 16-dword lines.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int ADDR_W    = 30;
  localparam int CNT_W     = 16;
  localparam int CLS_W     = 3;
  localparam int BYTES_PER_BEAT = 4;

  function automatic logic [ADDR_W-1:0] line_mask(input logic [CLS_W-1:0] lg);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < int'(lg));
    return m;
  endfunction
endpackage

// File: rtl/rbs_addr_track.sv
module rbs_addr_track
  import rbs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int STEP = BYTES_PER_BEAT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          beat,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_nxt,
  output logic [CW-1:0] cnt_nxt
);
  localparam logic [CW-1:0] STEP_C = CW'(STEP);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (start) begin
      addr_nxt = start_addr;
      cnt_nxt  = '0;
    end else if (beat) begin
      addr_nxt = addr_q + 1'b1;
      cnt_nxt  = (cnt_q > {CW{1'b1}} - STEP_C) ? {CW{1'b1}} : cnt_q + STEP_C;
    end else begin
      addr_nxt = addr_q;
      cnt_nxt  = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_nxt;
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rbs_line_bound.sv
module rbs_line_bound
  import rbs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]    addr,
  input  logic [CLS_W-1:0] cls_log2,
  output logic             on_bound
);
  logic [AW-1:0] mask;
  always_comb begin
    mask     = line_mask(cls_log2);
    on_bound = ((addr & mask) == '0);
  end
endmodule

// File: rtl/rbs_term_ctrl.sv
module rbs_term_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic align_en,
  input  logic start,
  input  logic ack,
  input  logic afull,
  input  logic other_pend,
  input  logic bound_nxt,
  input  logic limit_hit,
  output logic stop_req,
  output logic handover_req,
  output logic busy
);
  logic afull_seen;
  logic stop_trig, hand_trig;

  always_comb begin
    if (align_en) begin
      stop_trig = (afull | afull_seen) & bound_nxt;
      hand_trig = limit_hit & other_pend & bound_nxt;
    end else begin
      stop_trig = afull;
      hand_trig = limit_hit & other_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      afull_seen   <= 1'b0;
      stop_req     <= 1'b0;
      handover_req <= 1'b0;
    end else if (start || ack) begin
      busy         <= start;
      afull_seen   <= 1'b0;
      stop_req     <= 1'b0;
      handover_req <= 1'b0;
    end else if (busy) begin
      afull_seen   <= afull_seen | afull;
      stop_req     <= stop_req | stop_trig;
      handover_req <= handover_req | hand_trig;
    end
  end
endmodule

// File: rtl/rd_burst_shaper.sv
module rd_burst_shaper
  import rbs_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align_en,
  input  logic [CLS_W-1:0] cls_log2,
  input  logic             txn_start,
  input  logic [AW-1:0]    start_addr,
  input  logic             beat,
  input  logic             fifo_afull,
  input  logic [CW-1:0]    arb_limit,
  input  logic             other_pend,
  input  logic             burst_end_ack,
  output logic             stop_req,
  output logic             handover_req,
  output logic [AW-1:0]    rd_addr
);
  logic [AW-1:0] addr_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          bound_nxt;
  logic          limit_hit;
  logic          busy;

  rbs_addr_track #(.AW(AW), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .start(txn_start), .start_addr(start_addr),
    .beat(beat), .addr_q(rd_addr), .addr_nxt(addr_nxt), .cnt_nxt(cnt_nxt)
  );

  rbs_line_bound #(.AW(AW)) u_bound (
    .addr(addr_nxt), .cls_log2(cls_log2), .on_bound(bound_nxt)
  );

  assign limit_hit = (arb_limit != '0) && (cnt_nxt >= arb_limit);

  rbs_term_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .start(txn_start),
    .ack(burst_end_ack), .afull(fifo_afull), .other_pend(other_pend),
    .bound_nxt(bound_nxt), .limit_hit(limit_hit), .stop_req(stop_req),
    .handover_req(handover_req), .busy(busy)
  );
endmodule

// File: rtl/rd_burst_shaper_chk.sv
module rd_burst_shaper_chk
  import rbs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             align_en,
  input logic [CLS_W-1:0] cls_log2,
  input logic             txn_start,
  input logic             fifo_afull,
  input logic             other_pend,
  input logic             burst_end_ack,
  input logic             busy,
  input logic             stop_req,
  input logic             handover_req,
  input logic [AW-1:0]    rd_addr
);
  logic [AW-1:0] m;
  logic          addr_aligned;
  always_comb begin
    m = '0;
    for (int i = 0; i < AW; i++) if (i < int'(cls_log2)) m[i] = 1'b1;
    addr_aligned = ((rd_addr & m) == '0);
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !burst_end_ack && !txn_start |=> stop_req);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end_ack |=> !stop_req && !handover_req);

  assert_plain_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en && busy && fifo_afull && !burst_end_ack && !txn_start |=> stop_req);

  assert_aligned_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) && $past(align_en) && $stable(cls_log2) |-> addr_aligned);

  assert_hand_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handover_req) |-> $past(other_pend));

  assert_aligned_hand_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handover_req) && $past(align_en) && $stable(cls_log2) |-> addr_aligned);
endmodule

bind rd_burst_shaper rd_burst_shaper_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .align_en(align_en), .cls_log2(cls_log2),
  .txn_start(txn_start), .fifo_afull(fifo_afull), .other_pend(other_pend),
  .burst_end_ack(burst_end_ack), .busy(busy), .stop_req(stop_req),
  .handover_req(handover_req), .rd_addr(rd_addr)
);

// File: tb/rd_burst_shaper_tb.sv
module rd_burst_shaper_tb;
  localparam int AW = 30;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic align_en = 0, txn_start = 0, beat = 0, fifo_afull = 0;
  logic other_pend = 0, burst_end_ack = 0;
  logic [2:0] cls_log2 = 3;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] arb_limit = '0;
  logic stop_req, handover_req;
  logic [AW-1:0] rd_addr;

  int checks = 0, errors = 0, cyc = 0;

  // bench model state
  logic [AW-1:0] m_addr;
  int  m_cnt;
  bit  m_busy, m_seen, m_stop, m_hand;

  rd_burst_shaper u_dut (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .cls_log2(cls_log2),
    .txn_start(txn_start), .start_addr(start_addr), .beat(beat),
    .fifo_afull(fifo_afull), .arb_limit(arb_limit), .other_pend(other_pend),
    .burst_end_ack(burst_end_ack), .stop_req(stop_req),
    .handover_req(handover_req), .rd_addr(rd_addr)
  );

  always #4 clk = ~clk;

  function automatic bit on_line(input logic [AW-1:0] a, input logic [2:0] lg);
    return (a % (32'd1 << lg)) == 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // compare all outputs to the model
  task automatic cmp_all(input string tag);
    chk(rd_addr == m_addr, {tag, " R2 addr"}, rd_addr, m_addr);
    chk(stop_req == m_stop, {tag, " R3 R4 R6 stop"}, stop_req, m_stop);
    chk(handover_req == m_hand, {tag, " R7 R8 R9 handover"}, handover_req, m_hand);
  endtask

  // advance the model by one edge using the currently driven inputs
  task automatic model_step();
    logic [AW-1:0] a_n;
    int  c_n;
    bit  bnd, lim, st, ho;
    if (txn_start) begin a_n = start_addr; c_n = 0; end
    else if (beat) begin a_n = m_addr + 1; c_n = (m_cnt + 4 > 65535) ? 65535 : m_cnt + 4; end
    else begin a_n = m_addr; c_n = m_cnt; end
    bnd = on_line(a_n, cls_log2);
    lim = (arb_limit != 0) && (c_n >= int'(arb_limit));
    st  = align_en ? ((fifo_afull || m_seen) && bnd) : fifo_afull;
    ho  = lim && other_pend && (align_en ? bnd : 1'b1);
    if (txn_start || burst_end_ack) begin
      m_busy = txn_start; m_seen = 0; m_stop = 0; m_hand = 0;
    end else if (m_busy) begin
      m_seen = m_seen || fifo_afull;
      m_stop = m_stop || st;
      m_hand = m_hand || ho;
    end
    m_addr = a_n; m_cnt = c_n;
  endtask

  // one cycle: model takes inputs, edge, then sample at negedge
  task automatic step();
    model_step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic clear_in();
    txn_start = 0; beat = 0; fifo_afull = 0; other_pend = 0; burst_end_ack = 0;
  endtask

  task automatic begin_burst(input logic [AW-1:0] a);
    clear_in(); txn_start = 1; start_addr = a; step(); txn_start = 0;
  endtask

  task automatic end_burst();
    clear_in(); burst_end_ack = 1; step(); burst_end_ack = 0;
    cmp_all("ack");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n_edge;
    void'($urandom(32'h5EED_0017));
    m_addr = '0; m_cnt = 0; m_busy = 0; m_seen = 0; m_stop = 0; m_hand = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stop_req == 0, "R1 stop after reset", stop_req, 0);
    chk(handover_req == 0, "R1 handover after reset", handover_req, 0);
    chk(rd_addr == 0, "R1 addr after reset", rd_addr, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: unaligned mode stops on next cycle
    align_en = 0; cls_log2 = 3;
    begin_burst(30'd5);
    chk(rd_addr == 5, "R2 start load", rd_addr, 5);
    beat = 1; step();
    chk(rd_addr == 6, "R2 beat increments", rd_addr, 6);
    fifo_afull = 1; step(); fifo_afull = 0;
    chk(stop_req == 1, "R3 plain stop next cycle", stop_req, 1);
    beat = 0; step(); step();
    chk(stop_req == 1, "R6 stop held", stop_req, 1);
    end_burst();
    chk(stop_req == 0, "R6 stop cleared by ack", stop_req, 0);

    // R4/R10: aligned mode, 8-dword line, afull at addr 3 waits to 8
    align_en = 1; cls_log2 = 3;
    begin_burst(30'd2);
    beat = 1; step();                 // addr 3
    fifo_afull = 1; step(); fifo_afull = 0; // addr 4, no stop
    chk(stop_req == 0, "R4 no stop mid-line", stop_req, 0);
    n_edge = 0;
    while (!stop_req && n_edge < 20) begin step(); n_edge++; end
    chk(rd_addr == 8, "R4 R10 stop at 8-dword line", rd_addr, 8);
    cmp_all("R4 directed");
    end_burst();

    // R10: 16-dword line, same start reaches 16
    cls_log2 = 4;
    begin_burst(30'd2);
    beat = 1; step();
    fifo_afull = 1; step(); fifo_afull = 0;
    n_edge = 0;
    while (!stop_req && n_edge < 30) begin step(); n_edge++; end
    chk(rd_addr == 16, "R10 stop at 16-dword line", rd_addr, 16);
    end_burst();

    // R5: already on boundary, no beat -> immediate stop
    cls_log2 = 3;
    begin_burst(30'd24);
    beat = 0; fifo_afull = 1; step(); fifo_afull = 0;
    chk(stop_req == 1, "R5 immediate stop on boundary", stop_req, 1);
    chk(rd_addr == 24, "R5 no extra line", rd_addr, 24);
    end_burst();

    // R8: plain handover exactly when count reaches limit (16 bytes = 4 beats)
    align_en = 0; arb_limit = 16;
    begin_burst(30'd1);
    other_pend = 1; beat = 1;
    step(); step(); step();
    chk(handover_req == 0, "R8 no handover below limit", handover_req, 0);
    step();
    chk(handover_req == 1, "R8 handover at limit", handover_req, 1);
    end_burst();

    // R9: aligned handover waits for boundary (start 1, limit reached at 5, line at 8)
    align_en = 1;
    begin_burst(30'd1);
    other_pend = 1; beat = 1;
    repeat (5) step();
    chk(handover_req == 0, "R9 handover deferred", handover_req, 0);
    step(); step();
    chk(handover_req == 1 && rd_addr == 8, "R9 handover on boundary", rd_addr, 8);
    end_burst();

    // R7: zero limit disables handover
    arb_limit = 0;
    begin_burst(30'd0);
    other_pend = 1; beat = 1;
    repeat (20) step();
    chk(handover_req == 0, "R7 zero limit no handover", handover_req, 0);
    end_burst();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit prev_stop;
      prev_stop = stop_req;
      clear_in();
      if (i % 200 == 0) begin
        align_en = $urandom_range(0, 1);
        cls_log2 = $urandom_range(0, 1) ? 3'd3 : 3'd4;
        arb_limit = CW'($urandom_range(0, 3) * 16);
      end
      if ((stop_req || handover_req) && $urandom_range(0, 3) == 0) burst_end_ack = 1;
      else if (!m_busy && $urandom_range(0, 2) == 0) begin
        txn_start = 1; start_addr = AW'($urandom_range(0, 200));
      end else begin
        beat = $urandom_range(0, 3) != 0;
        fifo_afull = $urandom_range(0, 9) == 0;
        other_pend = $urandom_range(0, 1);
      end
      step();
      cmp_all("rand");
      if (align_en && !prev_stop && stop_req)
        chk(on_line(rd_addr, cls_log2), "R4 random stop aligned", rd_addr % (1 << cls_log2), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule